// File: doc/BRIEF.md
# MDIO Single-Command Management Controller

This block is a management-bus master for Clause 22 PHY access. Software runs one frame per command: for a write it first loads the 16-bit value into the data register and then writes the command register. For a read it writes the command register alone. While the frame is on the wire, the start bit of the command register reads back as one. It clears by itself when the last bit has gone out.

The controller divides the system clock down to MDC. It drives MDIO on each falling MDC edge and samples MDIO on each rising MDC edge. During a read it releases the pin from the turnaround onward. The 16 result bits land in the upper half of the data register. A status bit records whether the PHY drove the second turnaround bit low. If it did not, software treats the address as having no device.

Register select: 0 is the command register, 1 is the data register, 2 is the status register and 3 reads as zero. Reads of the register interface are combinational.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, every register reads zero, MDC is low and MDIO is released (output enable low, output low).
- R2: A write to the command register (select 0) is accepted when it has bit 20 set, exactly one of bits 17 (read) or 16 (write) set, and the controller is idle. Bit 20 then reads one for exactly 128*DIV_HALF clocks. Bits 17/16, 12:8 and 4:0 read back the operation, PHY address and register address.
- R3: A command is ignored in three cases: it is written while busy, it has bit 20 clear, or it does not have exactly one of bits 17/16 set. The command fields and the frame in progress stay unchanged.
- R4: A frame is 64 bits, sent MSB first: 32 ones, start 01, opcode 10 for read or 01 for write, 5-bit PHY address, 5-bit register address, 2 turnaround bits, then 16 data bits.
- R5: MDC is low while idle. During a frame, each MDC high phase and each low phase lasts DIV_HALF clocks, starting low. While MDIO is driven, its value changes only on the clock where MDC falls.
- R6: In a write frame the master drives MDIO for all 64 bits. The turnaround is 10 and the data is bits 15:0 of the data register, as they stood when the command was accepted.
- R7: In a read frame the master releases MDIO (output enable low) from the first turnaround bit until the frame ends.
- R8: A read samples MDIO on the rising MDC edge of each data bit. At frame end the 16 bits appear in bits 31:16 of the data register, MSB first.
- R9: At the end of a read, status bit 0 takes the value sampled on the second turnaround bit: 1 means no valid response, 0 means the PHY answered. Write frames leave the status bit unchanged.
- R10: A write to the data register (select 1) stores bits 15:0 at any time. Bits 31:16 change only at the end of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 command, 1 data, 2 status) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_sel_i |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The assertions assume that mdio_i only matters while the master has released the pin. They also assume the register interface holds its inputs stable across each clock edge.

The bench meets both assumptions. Its PHY model changes mdio_i only at the falling system clock and drives a value only on turnaround and data bits of a read. Register writes are applied at the falling clock, and the bench deliberately issues some commands during a busy frame and some malformed commands, to exercise the ignore rules.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int FRAME_BITS  = 64;
  localparam int PRE_BITS    = 32;
  localparam int TA_IDX      = 46;
  localparam int DATA_IDX    = 48;
  localparam int DATA_W      = 16;
  localparam int ADDR_W      = 5;
  localparam int IDX_W       = $clog2(FRAME_BITS);
  localparam int CMD_GO_BIT  = 20;
  localparam int CMD_RD_BIT  = 17;
  localparam int CMD_WR_BIT  = 16;
  localparam int CMD_PHY_LSB = 8;
  localparam int CMD_REG_LSB = 0;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          tick;

  assign tick   = run_i && (cnt_q == CW'(DIV_HALF - 1));
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              active_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ta_bad_o
);
  logic                  active_q, rd_q, ta_bad_q, last;
  logic [IDX_W-1:0]      idx_q;
  logic [FRAME_BITS-1:0] sh_q, frame_d;
  logic [DATA_W-1:0]     rsh_q;

  always_comb begin
    frame_d = {{PRE_BITS{1'b1}}, 2'b01,
               rd_i ? 2'b10 : 2'b01,
               phy_i, reg_i,
               rd_i ? 2'b11 : 2'b10,
               rd_i ? {DATA_W{1'b1}} : wdata_i};
  end

  assign last      = idx_q == IDX_W'(FRAME_BITS - 1);
  assign done_o    = active_q && fall_i && last;
  assign mdio_oe_o = active_q && !(rd_q && (idx_q >= IDX_W'(TA_IDX)));
  assign mdio_o    = mdio_oe_o ? sh_q[FRAME_BITS-1] : 1'b0;
  assign active_o  = active_q;
  assign idx_o     = idx_q;
  assign rdata_o   = rsh_q;
  assign ta_bad_o  = ta_bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      idx_q    <= '0;
      sh_q     <= '0;
      rsh_q    <= '0;
      ta_bad_q <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      rd_q     <= rd_i;
      idx_q    <= '0;
      sh_q     <= frame_d;
      ta_bad_q <= 1'b0;
    end else if (active_q) begin
      if (fall_i) begin
        if (last) active_q <= 1'b0;
        else      idx_q    <= idx_q + 1'b1;
        sh_q <= {sh_q[FRAME_BITS-2:0], 1'b0};
      end
      if (rise_i && rd_q) begin
        // second turnaround bit must be pulled low by the PHY
        if (idx_q == IDX_W'(TA_IDX + 1)) ta_bad_q <= mdio_i;
        if (idx_q >= IDX_W'(DATA_IDX))   rsh_q    <= {rsh_q[DATA_W-2:0], mdio_i};
      end
    end
  end
endmodule

// File: rtl/mdio_cmd_regs.sv
module mdio_cmd_regs
  import mdio_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rd_result_i,
  input  logic              ta_bad_i,
  output logic              start_o,
  output logic              op_rd_o,
  output logic [ADDR_W-1:0] phy_o,
  output logic [ADDR_W-1:0] reg_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              inv_o
);
  logic              op_rd_q, op_wr_q, inv_q;
  logic [ADDR_W-1:0] phy_q, reg_q;
  logic [DATA_W-1:0] wr_data_q, rd_data_q;
  reg_sel_e          sel;

  assign sel     = reg_sel_e'(sel_i);
  assign start_o = we_i && (sel == SEL_CMD) && wdata_i[CMD_GO_BIT] && !busy_i &&
                   (wdata_i[CMD_RD_BIT] ^ wdata_i[CMD_WR_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_rd_q   <= 1'b0;
      op_wr_q   <= 1'b0;
      phy_q     <= '0;
      reg_q     <= '0;
      wr_data_q <= '0;
      rd_data_q <= '0;
      inv_q     <= 1'b0;
    end else begin
      if (start_o) begin
        op_rd_q <= wdata_i[CMD_RD_BIT];
        op_wr_q <= wdata_i[CMD_WR_BIT];
        phy_q   <= wdata_i[CMD_PHY_LSB +: ADDR_W];
        reg_q   <= wdata_i[CMD_REG_LSB +: ADDR_W];
      end
      if (we_i && sel == SEL_DATA) wr_data_q <= wdata_i[DATA_W-1:0];
      if (done_i && op_rd_q) begin
        rd_data_q <= rd_result_i;
        inv_q     <= ta_bad_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_CMD: begin
        rdata_o[CMD_GO_BIT]                 = busy_i;
        rdata_o[CMD_RD_BIT]                 = op_rd_q;
        rdata_o[CMD_WR_BIT]                 = op_wr_q;
        rdata_o[CMD_PHY_LSB +: ADDR_W]      = phy_q;
        rdata_o[CMD_REG_LSB +: ADDR_W]      = reg_q;
      end
      SEL_DATA: rdata_o = {rd_data_q, wr_data_q};
      SEL_STAT: rdata_o[0] = inv_q;
      SEL_NONE: rdata_o = '0;
    endcase
  end

  assign op_rd_o   = op_rd_q;
  assign phy_o     = phy_q;
  assign reg_o     = reg_q;
  assign wr_data_o = wr_data_q;
  assign inv_o     = inv_q;
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_cmd_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic              busy, start, done, rise, fall, ta_bad;
  logic              cmd_rd, rd_invalid;
  logic [ADDR_W-1:0] cmd_phy, cmd_reg;
  logic [DATA_W-1:0] wr_data, rd_result;
  logic [IDX_W-1:0]  bit_idx;

  mdio_cmd_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .sel_i       (reg_sel_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .busy_i      (busy),
    .done_i      (done),
    .rd_result_i (rd_result),
    .ta_bad_i    (ta_bad),
    .start_o     (start),
    .op_rd_o     (cmd_rd),
    .phy_o       (cmd_phy),
    .reg_o       (cmd_reg),
    .wr_data_o   (wr_data),
    .inv_o       (rd_invalid)
  );

  mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_eng u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .rd_i      (reg_wdata_i[CMD_RD_BIT]),
    .phy_i     (reg_wdata_i[CMD_PHY_LSB +: ADDR_W]),
    .reg_i     (reg_wdata_i[CMD_REG_LSB +: ADDR_W]),
    .wdata_i   (wr_data),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .active_o  (busy),
    .idx_o     (bit_idx),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .done_o    (done),
    .rdata_o   (rd_result),
    .ta_bad_o  (ta_bad)
  );
endmodule

// File: rtl/mdio_cmd_chk.sv
module mdio_cmd_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy,
  input logic       cmd_rd,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic [5:0] bit_idx,
  input logic [4:0] cmd_phy,
  input logic [4:0] cmd_reg,
  input logic       rd_invalid
);
  // R5
  mdc_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc);
  // R5
  mdio_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc));
  // R7
  rd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cmd_rd && bit_idx >= 6'd46) |-> !mdio_oe);
  // R6
  wr_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !cmd_rd) |-> mdio_oe);
  // R3
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(cmd_phy) && $stable(cmd_reg) && $stable(cmd_rd)));
  // R9
  inv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(rd_invalid));
endmodule

bind mdio_cmd_ctrl mdio_cmd_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy       (busy),
  .cmd_rd     (cmd_rd),
  .mdc        (mdc_o),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe_o),
  .bit_idx    (bit_idx),
  .cmd_phy    (cmd_phy),
  .cmd_reg    (cmd_reg),
  .rd_invalid (rd_invalid)
);

// File: tb/mdio_cmd_ctrl_bench.sv
module mdio_cmd_ctrl_bench;
  localparam int DH = 2;
  localparam int FRAME_CLKS = 128 * DH;
  localparam int WD_LIMIT = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_sel_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  mdio_cmd_ctrl #(.DIV_HALF(DH)) u_mdio_cmd_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .mdc_o(mdc_o),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  always #5 clk_i = ~clk_i;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference model state
  bit        m_busy, m_rd, m_wr, m_inv;
  int        m_k;
  bit [4:0]  m_phy, m_reg;
  bit [15:0] m_wd, m_rdd, m_fd;
  bit        phy_present = 0;
  bit [15:0] phy_reply = '0;

  function automatic bit [63:0] ref_frame();
    bit [63:0] f;
    f = {32'hFFFF_FFFF, 2'b01, (m_rd ? 2'b10 : 2'b01), m_phy, m_reg,
         (m_rd ? 2'b11 : 2'b10), (m_rd ? 16'hFFFF : m_fd)};
    return f;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_rd = 0; m_wr = 0; m_inv = 0; m_k = 0;
      m_phy = 0; m_reg = 0; m_wd = 0; m_rdd = 0; m_fd = 0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      if (m_busy) begin
        m_k++;
        if (m_k == FRAME_CLKS) begin
          m_busy = 0;
          m_k = 0;
          if (m_rd) begin
            m_inv = !phy_present;
            m_rdd = phy_present ? phy_reply : 16'hFFFF;
          end
        end
      end
      if (!was_busy && reg_we_i && reg_sel_i == 2'd0 && reg_wdata_i[20] &&
          (reg_wdata_i[17] != reg_wdata_i[16])) begin
        m_busy = 1; m_k = 0;
        m_rd = reg_wdata_i[17]; m_wr = reg_wdata_i[16];
        m_phy = reg_wdata_i[12:8]; m_reg = reg_wdata_i[4:0];
        m_fd = m_wd;
      end
      if (reg_we_i && reg_sel_i == 2'd1) m_wd = reg_wdata_i[15:0];
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    #1;
    if (!finished) begin
      int b;
      bit e_mdc, e_oe, e_o;
      logic [31:0] e_rd;
      bit [63:0] fr;
      cycles++;
      b = (m_k / DH) / 2;
      fr = ref_frame();
      e_mdc = m_busy && (((m_k / DH) % 2) == 1);
      e_oe = m_busy && !(m_rd && b >= 46);
      e_o = e_oe ? fr[63 - b] : 1'b0;
      case (reg_sel_i)
        2'd0: e_rd = {11'b0, m_busy, 2'b0, m_rd, m_wr, 3'b0, m_phy, 3'b0, m_reg};
        2'd1: e_rd = {m_rdd, m_wd};
        2'd2: e_rd = {31'b0, m_inv};
        default: e_rd = '0;
      endcase
      check(mdc_o === e_mdc, "R5", "mdc", 32'(mdc_o), 32'(e_mdc));
      check(mdio_oe_o === e_oe, (m_rd ? "R7" : "R6"), "mdio_oe", 32'(mdio_oe_o), 32'(e_oe));
      check(mdio_o === e_o, "R4", "mdio_o", 32'(mdio_o), 32'(e_o));
      check(reg_rdata_o === e_rd, (reg_sel_i == 2'd0 && m_busy) ? "R2" : cur_req,
            "rdata", reg_rdata_o, e_rd);
      // PHY model: answers only on turnaround/data bits of a read
      if (m_busy && m_rd && phy_present && b >= 47)
        mdio_i = (b == 47) ? 1'b0 : phy_reply[63 - b];
      else
        mdio_i = 1'b1;
      if (cycles > WD_LIMIT) begin
        errors++;
        $display("FAIL watchdog expired act=%0d exp=%0d", cycles, WD_LIMIT);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        finished = 1;
        $finish;
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic view(input logic [1:0] sel, input int n);
    @(negedge clk_i);
    reg_sel_i = sel;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * FRAME_CLKS && m_busy; i++) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk_i);
    for (int s = 0; s < 4; s++) view(2'(s), 1);
    rst_ni = 1'b1;
    view(2'd1, 2);

    cur_req = "R10";
    wr(2'd1, 32'hDEAD_A5C3);
    view(2'd1, 2);

    cur_req = "R6";
    wr(2'd0, 32'h0011_0503);
    view(2'd0, 40);
    cur_req = "R3";
    wr(2'd0, 32'h0012_1F1F);
    wr(2'd1, 32'h0000_0F0F);
    view(2'd0, 20);
    wait_idle();

    cur_req = "R8";
    phy_present = 1; phy_reply = 16'h1234;
    wr(2'd0, 32'h0012_1F1F);
    view(2'd1, 10);
    wait_idle();
    view(2'd2, 3);
    view(2'd1, 3);

    cur_req = "R9";
    phy_present = 0;
    wr(2'd0, 32'h0012_0000);
    wait_idle();
    view(2'd2, 3);
    view(2'd1, 3);
    wr(2'd0, 32'h0011_0A11);
    view(2'd2, 10);
    wait_idle();
    view(2'd2, 3);

    cur_req = "R8";
    phy_present = 1; phy_reply = 16'h8001;
    wr(2'd0, 32'h0012_0102);
    wait_idle();
    view(2'd1, 2);
    view(2'd2, 2);

    cur_req = "R3";
    wr(2'd0, 32'h0013_0404);
    view(2'd0, 6);
    wr(2'd0, 32'h0002_0404);
    view(2'd0, 6);
    wr(2'd0, 32'h0010_0404);
    view(2'd0, 6);
    view(2'd3, 2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule